// File: doc/BRIEF.md
# Smart-Card Answer-to-Reset Transmitter

This block is the transmit side of a contact smart-card interface that announces the card after reset. It runs on the card clock. While the card reset line is low, or while the interface is strapped for the synchronous two-wire protocol, it keeps the shared open-drain I/O line released and stays idle. When reset goes high in asynchronous mode, it waits a fixed number of card-clock cycles. It then sends eight characters, one after the other, from a small programmable byte store, and raises a done flag after the last one.

Each character is a low start bit, eight data bits sent least significant first, an even-parity bit and a high guard interval. Every bit lasts one elementary time unit, a fixed count of card-clock cycles. The byte store is written through a simple address/data port. Its contents are not cleared by the card reset, so a programmed answer is sent again on every reset release.

Top module: `atr_tx`

## Requirements
- R1: While `card_rst_n` is low, `io_pull_low` is 0 (line released) and `atr_done` is 0 from the next clock edge on. All internal counters return to zero, so a later release starts the whole sequence again.
- R2: Let E0 be the first rising clock edge at which `card_rst_n` is sampled high with `sync_mode` low. `io_pull_low` first becomes 1 after edge E0+`START_DELAY` and is 0 before that.
- R3: Every transmitted bit, including each guard bit, holds its level for exactly `ETU_CYCLES` clock cycles (default 372).
- R4: A character is made of a start bit (line pulled low), then data bits 0 to 7 in that order (a data 1 releases the line), then a parity bit that makes the count of ones over data and parity even, then `GUARD_ETUS` released bits. The next character's start bit follows the guard at once, so one character spans (10+`GUARD_ETUS`)·`ETU_CYCLES` cycles.
- R5: A write takes place on a clock edge where `cfg_we` is 1, storing `cfg_wdata` at byte slot `cfg_addr`. The characters carry slots 0, 1, … `NUM_BYTES`-1 in that order.
- R6: `atr_done` rises after edge E0+`START_DELAY`+`NUM_BYTES`·(10+`GUARD_ETUS`)·`ETU_CYCLES`. It stays high, with the line released, until reset or synchronous mode is asserted.
- R7: While `sync_mode` is 1 nothing is sent and `atr_done` stays 0. Raising it during a transmission releases the line from the next edge on.
- R8: Pulling `card_rst_n` low in the middle of a transmission releases the line from the next edge on. The next release sends the whole sequence again from slot 0, after the full start delay.
- R9: The byte store keeps its contents through card resets: a sequence sent after a reset with no new writes carries the previously written bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| card_rst_n | input | 1 | Card reset line; low holds the block idle |
| sync_mode | input | 1 | 1 selects the synchronous protocol and suppresses the answer |
| cfg_we | input | 1 | Byte store write enable |
| cfg_addr | input | 3 | Byte store slot to write |
| cfg_wdata | input | 8 | Byte to write |
| io_pull_low | output | 1 | 1 pulls the open-drain I/O line low, 0 releases it |
| atr_done | output | 1 | High once the last character's guard time has ended |

## Verification
The bench compares the line against an arithmetic model on every cycle. An off-by-one in the start delay or in the unit counter therefore shows up as a shifted edge, and a wrong bit order or parity sense shows up inside the data field. All 256 byte values pass through the transmitter, so the parity rule is tested against every data pattern, not only against a few chosen ones. Aborts by reset and by synchronous mode are placed in the middle of a character. A design that kept its byte or bit position across the abort, or that shortened the start delay on restart, would send the wrong first character. A store that cleared on reset would send zeros on the rerun.

// File: rtl/atr_pkg.sv
package atr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEND = 2'd2,
    ST_DONE = 2'd3
  } atr_state_e;
endpackage

// File: rtl/atr_interval_timer.sv
module atr_interval_timer #(
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          clear,
  input  logic [TW-1:0] limit_m1,
  output logic          hit
);
  logic [TW-1:0] cnt;

  assign hit = (cnt == limit_m1);

  always_ff @(posedge clk) begin
    if (clear)    cnt <= '0;
    else if (hit) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  // R3: the count never runs past the current interval length
  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (clear)
    cnt <= limit_m1);
endmodule

// File: rtl/atr_byte_store.sv
module atr_byte_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/atr_frame_bit.sv
module atr_frame_bit #(
  parameter int DW = 8,
  parameter int BW = 4
) (
  input  logic [DW-1:0] data,
  input  logic [BW-1:0] bit_idx,
  output logic          level
);
  localparam logic [BW-1:0] PAR_POS = BW'(DW + 1);

  always_comb begin
    level = 1'b1;
    if (bit_idx == '0) level = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (bit_idx == BW'(i + 1)) level = data[i];
    end
    if (bit_idx == PAR_POS) level = ^data;
  end
endmodule

// File: rtl/atr_tx.sv
module atr_tx #(
  parameter int ETU_CYCLES  = 372,
  parameter int START_DELAY = 400,
  parameter int NUM_BYTES   = 8,
  parameter int GUARD_ETUS  = 2,
  parameter int DW          = 8
) (
  input  logic       clk,
  input  logic       card_rst_n,
  input  logic       sync_mode,
  input  logic       cfg_we,
  input  logic [2:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output logic       io_pull_low,
  output logic       atr_done
);
  import atr_pkg::*;

  localparam int BPC     = 1 + DW + 1 + GUARD_ETUS;
  localparam int BW      = $clog2(BPC);
  localparam int AW      = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam int TMAX    = (ETU_CYCLES > START_DELAY) ? ETU_CYCLES : START_DELAY;
  localparam int TW      = $clog2(TMAX + 1);
  localparam logic [BW-1:0] LAST_BIT   = BW'(BPC - 1);
  localparam logic [BW-1:0] GUARD_POS  = BW'(DW + 2);
  localparam logic [AW-1:0] LAST_BYTE  = AW'(NUM_BYTES - 1);
  localparam logic [TW-1:0] ETU_M1     = TW'(ETU_CYCLES - 1);
  localparam logic [TW-1:0] DELAY_M1   = TW'(START_DELAY - 1);

  atr_state_e    state;
  logic [BW-1:0] bit_idx, nxt_bit;
  logic [AW-1:0] byte_idx, nxt_byte;
  logic          hold, tick, tmr_clear, level, last_bit, last_byte;
  logic [TW-1:0] tmr_limit;
  logic [DW-1:0] rd_byte;

  assign hold      = !card_rst_n || sync_mode;
  assign tmr_clear = hold || (state == ST_IDLE) || (state == ST_DONE);
  assign tmr_limit = (state == ST_WAIT) ? DELAY_M1 : ETU_M1;
  assign last_bit  = (bit_idx == LAST_BIT);
  assign last_byte = (byte_idx == LAST_BYTE);

  atr_interval_timer #(.TW(TW)) u_timer (
    .clk(clk), .clear(tmr_clear), .limit_m1(tmr_limit), .hit(tick)
  );

  atr_byte_store #(.DW(DW), .DEPTH(NUM_BYTES), .AW(AW)) u_store (
    .clk(clk), .we(cfg_we), .waddr(cfg_addr[AW-1:0]), .wdata(cfg_wdata[DW-1:0]),
    .raddr(nxt_byte), .rdata(rd_byte)
  );

  atr_frame_bit #(.DW(DW), .BW(BW)) u_frame (
    .data(rd_byte), .bit_idx(nxt_bit), .level(level)
  );

  always_comb begin
    nxt_bit  = '0;
    nxt_byte = '0;
    if (state == ST_SEND) begin
      if (last_bit) begin
        nxt_byte = byte_idx + 1'b1;
      end else begin
        nxt_bit  = bit_idx + 1'b1;
        nxt_byte = byte_idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (hold) begin
      state       <= ST_IDLE;
      bit_idx     <= '0;
      byte_idx    <= '0;
      io_pull_low <= 1'b0;
      atr_done    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: state <= ST_WAIT;
        ST_WAIT: begin
          if (tick) begin
            state       <= ST_SEND;
            bit_idx     <= '0;
            byte_idx    <= '0;
            io_pull_low <= !level;
          end
        end
        ST_SEND: begin
          if (tick) begin
            if (last_bit && last_byte) begin
              state       <= ST_DONE;
              io_pull_low <= 1'b0;
              atr_done    <= 1'b1;
            end else begin
              bit_idx     <= nxt_bit;
              byte_idx    <= nxt_byte;
              io_pull_low <= !level;
            end
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  // R1: hold releases the line and clears done on the next edge
  assert_hold_releases_R1: assert property (@(posedge clk)
    hold |=> (!io_pull_low && !atr_done));

  // R4: the start bit pulls the line low
  assert_start_low_R4: assert property (@(posedge clk) disable iff (hold)
    (state == ST_SEND && bit_idx == '0) |-> io_pull_low);

  // R4: guard bits leave the line released
  assert_guard_high_R4: assert property (@(posedge clk) disable iff (hold)
    (state == ST_SEND && bit_idx >= GUARD_POS) |-> !io_pull_low);

  // R5: the byte slot only moves at a character boundary
  assert_byte_stable_R5: assert property (@(posedge clk) disable iff (hold)
    (state == ST_SEND && $past(state) == ST_SEND && bit_idx != '0) |-> $stable(byte_idx));

  // R6: once done, the line stays released
  assert_done_released_R6: assert property (@(posedge clk) disable iff (hold)
    atr_done |-> !io_pull_low);
endmodule

// File: tb/atr_tx_bench.sv
module atr_tx_bench;
  localparam int E = 5;
  localparam int D = 7;
  localparam int G = 2;
  localparam int N = 8;
  localparam int F = 10 + G;
  localparam int TOTAL = D + N * F * E;

  logic       clk = 1'b0;
  logic       card_rst_n = 1'b0;
  logic       sync_mode = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       io_pull_low, atr_done;
  logic [7:0] pat [N];
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  atr_tx #(.ETU_CYCLES(E), .START_DELAY(D), .NUM_BYTES(N), .GUARD_ETUS(G), .DW(8)) u_atr_tx (
    .clk(clk), .card_rst_n(card_rst_n), .sync_mode(sync_mode), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .io_pull_low(io_pull_low), .atr_done(atr_done)
  );

  task automatic check(input string req, input logic act, input logic exp, input string what, input int t);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s t=%0d actual=%b expected=%b", req, what, t, act, exp);
    end
  endtask

  function automatic logic exp_pull(input int t);
    int u, ch, b;
    logic [7:0] d;
    if (t < D || t >= TOTAL) return 1'b0;
    u  = t - D;
    ch = u / (F * E);
    b  = (u % (F * E)) / E;
    d  = pat[ch];
    if (b == 0) return 1'b1;
    if (b <= 8) return !d[b-1];
    if (b == 9) return !(^d);
    return 1'b0;
  endfunction

  function automatic string tag_of(input int t);
    int u;
    if (t < D) return "R2";
    if (t >= TOTAL) return "R6";
    u = (t - D) % E;
    if (u == 0 || u == E - 1) return "R3";
    return "R4";
  endfunction

  task automatic load_pat();
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 3'(i); cfg_wdata = pat[i];
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // kind 0: no abort, 1: reset abort (R8), 2: sync abort (R7), 3: sync held whole run (R7)
  task automatic burst(input int abort_at, input int kind);
    bit aborted = 0;
    @(negedge clk);
    card_rst_n = 1'b1;
    @(posedge clk);
    for (int t = 0; t <= TOTAL + 4; t++) begin
      @(negedge clk);
      if (kind == 3) begin
        check("R7", io_pull_low, 1'b0, "sync io", t);
        check("R7", atr_done, 1'b0, "sync done", t);
      end else if (aborted) begin
        check(kind == 1 ? "R8" : "R7", io_pull_low, 1'b0, "abort io", t);
        check(kind == 1 ? "R8" : "R7", atr_done, 1'b0, "abort done", t);
        if (t > abort_at + 4) break;
      end else begin
        check(tag_of(t), io_pull_low, exp_pull(t), "io", t);
        check("R6", atr_done, (t >= TOTAL) ? 1'b1 : 1'b0, "done", t);
      end
      if (t == abort_at) begin
        aborted = 1;
        if (kind == 1) card_rst_n = 1'b0;
        else sync_mode = 1'b1;
      end
    end
    @(negedge clk);
    card_rst_n = 1'b0;
    sync_mode  = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", io_pull_low, 1'b0, "reset io", 0);
    check("R1", atr_done, 1'b0, "reset done", 0);

    // R5: distinct pattern, order of slots visible
    pat = '{8'h01, 8'h80, 8'hAA, 8'h55, 8'h00, 8'hFF, 8'h3C, 8'hC3};
    load_pat();
    burst(-1, 0);

    // R4 parity over every byte value
    for (int blk = 0; blk < 32; blk++) begin
      for (int i = 0; i < N; i++) pat[i] = 8'(blk * 8 + i);
      load_pat();
      burst(-1, 0);
    end

    // R8 abort mid character, then R9 rerun without rewriting
    pat = '{8'h5A, 8'hE1, 8'h0F, 8'h96, 8'h11, 8'h7E, 8'h42, 8'hBD};
    load_pat();
    burst(D + 3 * F * E + 2 * E + 2, 1);
    burst(-1, 0); // R9: stored bytes survive reset, full delay again (R1)

    // R7: synchronous mode, whole run and mid-run
    sync_mode = 1'b1;
    burst(-1, 3);
    burst(D + 2 * F * E + 4 * E + 1, 2);
    burst(-1, 0); // R1: restart after sync abort from slot 0

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule